// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block breaks a loop of arbitrary element count into pieces that a vector unit with a fixed maximum length can process. A start request carries the total count. The block then hands out a series of chunks over a valid/ready channel. Each chunk gives the starting element index and the number of active elements.

The odd-sized remainder (the count modulo the maximum length) goes out first, starting at index 0. Every later chunk is full length. Each start index equals the previous start plus the previous length. The final chunk carries a last flag. One cycle after the final handshake, a single-cycle done pulse closes the sequence.

When the count is an exact multiple of the maximum length, the remainder piece has length zero. By default the block skips it. A parameter can select emitting it instead, for consumers that expect a fixed number of chunks (count divided by the maximum, plus one).

Top module: `stripSeq`

## Requirements
- R1: After reset, chunkValid and seqDone are both low.
- R2: A start accepted with count n gives, in the next cycle, a first chunk with chunkLow = 0 and chunkLen = n mod MAX_VL, whenever that remainder is nonzero.
- R3: Every chunk after the first has chunkLen = MAX_VL, and its chunkLow equals the previous chunk's chunkLow plus its chunkLen.
- R4: A nonzero count produces n/MAX_VL + 1 chunks (integer division) when the remainder is nonzero or the empty piece is emitted. It produces n/MAX_VL chunks when the empty piece is skipped.
- R5: For a nonzero exact multiple of MAX_VL, the first chunk has chunkLen = MAX_VL when EMIT_EMPTY = 0. When EMIT_EMPTY = 1, the first chunk has chunkLen = 0 and chunkLow = 0.
- R6: chunkLast is high on the final chunk only, and on that chunk chunkLow + chunkLen = n.
- R7: While chunkValid is high and chunkReady is low, chunkLow, chunkLen and chunkLast hold their values and chunkValid stays high.
- R8: A start with n = 0 produces no chunk, and seqDone is high in the cycle after the start.
- R9: After the handshake of the final chunk, seqDone is high for exactly the next cycle, and chunkValid is low in that cycle.
- R10: A start request while chunkValid is high is ignored, and the running sequence continues unchanged.
- R11: A start request in the cycle where seqDone is high is accepted. Its first chunk (or, for n = 0, a new done pulse) follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Request to begin a sequence, sampled when no chunk is pending |
| totalIn | input | CNT_W | Total element count n, taken together with startReq |
| chunkReady | input | 1 | Consumer accepts the current chunk |
| chunkValid | output | 1 | A chunk is presented |
| chunkLow | output | CNT_W | Start element index of the chunk |
| chunkLen | output | $clog2(MAX_VL+1) | Active element count of the chunk |
| chunkLast | output | 1 | Chunk is the final one of the sequence |
| seqDone | output | 1 | One-cycle pulse marking the end of a sequence |

## Verification
Two functions can fall in the same cycle: the done pulse of one sequence and the acceptance of the next start. The bench watches for seqDone and raises startReq in that same cycle. It expects the new sequence's first chunk, or a fresh done pulse for a zero count, in the very next cycle.

A second overlap is a start arriving while a chunk is stalled or being handed over. Starts are driven in the middle of a sequence under random back-pressure, and the chunk stream must remain exactly that of the first request. A behavioural queue model judges every cycle for two configurations: the default one, and a short-length one that emits the empty piece.

// File: rtl/stripSeqPkg.sv
package stripSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_DONE = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;     // start accepted: capture count, prime first chunk
    logic advance;  // non-final chunk handed over: step to next chunk
  } seqStrobe_t;

endpackage

// File: rtl/stripSeqCtrl.sv
module stripSeqCtrl
  import stripSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       totalZero,
  input  logic       chunkReady,
  input  logic       chunkLast,
  output seqStrobe_t strobe,
  output logic       chunkValid,
  output logic       seqDone
);

  seqState_t stateQ, stateD;
  logic      accept;
  logic      handoff;

  assign accept  = startReq && (stateQ != ST_EMIT);
  assign handoff = (stateQ == ST_EMIT) && chunkReady;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_EMIT: if (handoff && chunkLast) stateD = ST_DONE;
      default: begin
        if (accept) stateD = totalZero ? ST_DONE : ST_EMIT;
        else        stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign strobe.load    = accept;
  assign strobe.advance = handoff && !chunkLast;
  assign chunkValid     = (stateQ == ST_EMIT);
  assign seqDone        = (stateQ == ST_DONE);

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid && chunkReady && chunkLast |=> seqDone && !chunkValid); // R9

  AST_ZERO_COUNT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !chunkValid && startReq && totalZero |=> seqDone && !chunkValid); // R8

  AST_DONE_NOT_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |-> !chunkValid); // R9

endmodule

// File: rtl/stripSeqDp.sv
module stripSeqDp
  import stripSeqPkg::*;
#(
  parameter int MAX_VL     = 64,
  parameter int CNT_W      = 16,
  parameter bit EMIT_EMPTY = 1'b0,
  parameter int VL_W       = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [CNT_W-1:0] totalIn,
  output logic             totalZero,
  output logic [CNT_W-1:0] chunkLow,
  output logic [VL_W-1:0]  chunkLen,
  output logic             chunkLast
);

  localparam logic [CNT_W-1:0] MVL_CNT = CNT_W'(MAX_VL);
  localparam logic [VL_W-1:0]  MVL_LEN = VL_W'(MAX_VL);

  logic [CNT_W-1:0] totalQ;
  logic [CNT_W-1:0] lowQ;
  logic [VL_W-1:0]  lenQ;
  logic [CNT_W-1:0] remCnt;
  logic [VL_W-1:0]  firstLen;
  logic [CNT_W:0]   endIdx;

  assign totalZero = (totalIn == '0);
  assign remCnt    = totalIn % MVL_CNT;

  generate
    if (EMIT_EMPTY) begin : gEmitEmpty
      assign firstLen = remCnt[VL_W-1:0];
    end else begin : gSkipEmpty
      assign firstLen = (remCnt == '0) ? MVL_LEN : remCnt[VL_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      totalQ <= '0;
      lowQ   <= '0;
      lenQ   <= '0;
    end else if (strobe.load) begin
      totalQ <= totalIn;
      lowQ   <= '0;
      lenQ   <= firstLen;
    end else if (strobe.advance) begin
      lowQ   <= lowQ + CNT_W'(lenQ);
      lenQ   <= MVL_LEN;
    end
  end

  assign endIdx    = {1'b0, lowQ} + (CNT_W + 1)'(lenQ);
  assign chunkLast = (endIdx == {1'b0, totalQ});
  assign chunkLow  = lowQ;
  assign chunkLen  = lenQ;

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    lenQ <= MVL_LEN); // R3

  AST_LOAD_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> lowQ == '0); // R2

endmodule

// File: rtl/stripSeq.sv
module stripSeq
  import stripSeqPkg::*;
#(
  parameter int MAX_VL     = 64,
  parameter int CNT_W      = 16,
  parameter bit EMIT_EMPTY = 1'b0,
  localparam int VL_W      = $clog2(MAX_VL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] totalIn,
  input  logic             chunkReady,
  output logic             chunkValid,
  output logic [CNT_W-1:0] chunkLow,
  output logic [VL_W-1:0]  chunkLen,
  output logic             chunkLast,
  output logic             seqDone
);

  seqStrobe_t strobe;
  logic       totalZero;

  stripSeqCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .totalZero  (totalZero),
    .chunkReady (chunkReady),
    .chunkLast  (chunkLast),
    .strobe     (strobe),
    .chunkValid (chunkValid),
    .seqDone    (seqDone)
  );

  stripSeqDp #(
    .MAX_VL     (MAX_VL),
    .CNT_W      (CNT_W),
    .EMIT_EMPTY (EMIT_EMPTY),
    .VL_W       (VL_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .totalIn   (totalIn),
    .totalZero (totalZero),
    .chunkLow  (chunkLow),
    .chunkLen  (chunkLen),
    .chunkLast (chunkLast)
  );

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid && !chunkReady |=> chunkValid && $stable(chunkLow)
      && $stable(chunkLen) && $stable(chunkLast)); // R7

  AST_LOW_STEPS_BY_LEN: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid && chunkReady && !chunkLast |=> chunkValid
      && chunkLow == $past(chunkLow) + CNT_W'($past(chunkLen))); // R3

  AST_LATER_CHUNKS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid && chunkReady && !chunkLast |=> chunkLen == VL_W'(MAX_VL)); // R3

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rstN)
    chunkValid && startReq && !chunkReady |=> chunkValid
      && $stable(chunkLow)); // R10

endmodule

// File: tb/tb_stripSeq.sv
module tb_stripSeq;

  localparam int CNT_W = 16;
  localparam int MVL0  = 64;
  localparam int MVL1  = 8;

  typedef struct {
    int low;
    int len;
    bit last;
  } chunk_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [CNT_W-1:0] totalIn = '0;
  logic readyQ = 1'b1;
  bit   randReady = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  logic                      v0, l0, d0, v1, l1, d1;
  logic [CNT_W-1:0]          lo0, lo1;
  logic [$clog2(MVL0+1)-1:0] n0;
  logic [$clog2(MVL1+1)-1:0] n1;

  stripSeq #(.MAX_VL(MVL0), .CNT_W(CNT_W), .EMIT_EMPTY(1'b0)) dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .totalIn(totalIn),
    .chunkReady(readyQ), .chunkValid(v0), .chunkLow(lo0), .chunkLen(n0),
    .chunkLast(l0), .seqDone(d0));

  stripSeq #(.MAX_VL(MVL1), .CNT_W(CNT_W), .EMIT_EMPTY(1'b1)) dutE (
    .clk(clk), .rstN(rstN), .startReq(startReq), .totalIn(totalIn),
    .chunkReady(readyQ), .chunkValid(v1), .chunkLow(lo1), .chunkLen(n1),
    .chunkLast(l1), .seqDone(d1));

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string phaseTag = "R1";

  chunk_t mq[2][$];
  bit     mDone[2];

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // behavioural reference, one per configuration
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 2; i++) begin
        mq[i].delete();
        mDone[i] = 1'b0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        int m;
        bit e, busy, nd;
        m = (i == 0) ? MVL0 : MVL1;
        e = (i == 1);
        busy = mq[i].size() > 0;
        nd = 1'b0;
        if (busy && readyQ) begin
          void'(mq[i].pop_front());
          if (mq[i].size() == 0) nd = 1'b1;
        end
        if (startReq && !busy) begin
          int n, lowAcc;
          n = int'(totalIn);
          lowAcc = 0;
          if ((n % m) != 0 || (e && n != 0)) begin
            mq[i].push_back('{0, n % m, (n % m) == n});
            lowAcc = n % m;
          end
          for (int k = 0; k < n / m; k++) begin
            mq[i].push_back('{lowAcc, m, lowAcc + m == n});
            lowAcc += m;
          end
          if (mq[i].size() == 0) nd = 1'b1;
        end
        mDone[i] = nd;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = 0; i < 2; i++) begin
        bit ev, av, ad, al;
        int alo, aln;
        ev  = mq[i].size() > 0;
        av  = (i == 0) ? v0 : v1;
        ad  = (i == 0) ? d0 : d1;
        al  = (i == 0) ? l0 : l1;
        alo = (i == 0) ? int'(lo0) : int'(lo1);
        aln = (i == 0) ? int'(n0) : int'(n1);
        chk(av == ev, {phaseTag, "/R4"}, $sformatf("valid inst%0d", i), av, ev);
        chk(ad == mDone[i], {phaseTag, "/R9"}, $sformatf("done inst%0d", i), ad, mDone[i]);
        if (ev && av) begin
          chk(alo == mq[i][0].low, {phaseTag, "/R3"}, $sformatf("low inst%0d", i), alo, mq[i][0].low);
          chk(aln == mq[i][0].len, {phaseTag, "/R2"}, $sformatf("len inst%0d", i), aln, mq[i][0].len);
          chk(al == mq[i][0].last, {phaseTag, "/R6"}, $sformatf("last inst%0d", i), al, mq[i][0].last);
        end
      end
    end
  end

  always @(negedge clk) readyQ <= randReady ? 1'($urandom % 2) : 1'b1;

  task automatic startSeq(int n);
    @(negedge clk);
    startReq = 1'b1;
    totalIn  = CNT_W'(n);
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (!v0 && !v1 && !d0 && !d1) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++;
        bad++;
        $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
        finishRun();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!v0 && !d0 && !v1 && !d1, "R1", "reset outputs", {v0, d0, v1, d1}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: remainder first, always ready
    phaseTag = "R2";
    startSeq(200);
    chk(v0 && lo0 == 0 && n0 == 8, "R2", "first chunk len", int'(n0), 8);
    waitIdle();

    // R7: back-pressure
    phaseTag = "R7";
    randReady = 1'b1;
    startSeq(200);
    waitIdle();
    startSeq(77);
    waitIdle();
    randReady = 1'b0;

    // R5: exact multiple, skip vs emit empty piece
    phaseTag = "R5";
    startSeq(128);
    chk(n0 == 64 && lo0 == 0, "R5", "skip empty first len", int'(n0), 64);
    chk(v1 && n1 == 0 && lo1 == 0, "R5", "emitted empty first len", int'(n1), 0);
    waitIdle();

    // R8: zero count
    phaseTag = "R8";
    startSeq(0);
    chk(d0 && !v0 && d1 && !v1, "R8", "done after zero start", {d0, v0}, 2);
    waitIdle();

    // R10: starts while busy are ignored
    phaseTag = "R10";
    randReady = 1'b1;
    startSeq(100);
    repeat (2) startSeq(5);
    startSeq(33);
    waitIdle();
    randReady = 1'b0;

    // R11: start in the done cycle
    phaseTag = "R11";
    startSeq(70);
    while (!d0) @(negedge clk);
    startReq = 1'b1;
    totalIn  = CNT_W'(3);
    @(negedge clk);
    startReq = 1'b0;
    chk(v0 && n0 == 3 && l0, "R11", "chunk after done-cycle start", int'(n0), 3);
    waitIdle();
    startSeq(64);
    while (!d0) @(negedge clk);
    startReq = 1'b1;
    totalIn  = '0;
    @(negedge clk);
    startReq = 1'b0;
    chk(d0 && !v0, "R11", "done again after zero start", d0, 1);
    waitIdle();

    // R6: single full chunk and remainder plus many
    phaseTag = "R6";
    randReady = 1'b1;
    startSeq(64);
    waitIdle();
    startSeq(64 * 3 + 1);
    waitIdle();
    startSeq(1);
    waitIdle();
    randReady = 1'b0;

    finishRun();
  end

endmodule